// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block passes an 18-bit word from an A port to a B port and from B back to A, without inversion. Each direction has its own enable, level control and clock control. The level control selects how the direction's storage register behaves. While it is high, the register reloads from the input on every system clock cycle (transparent). While it is low, the register holds its value. It loads only when the sampled direction clock goes from low to high.

The design is fully synchronous. A free-running system clock samples every control input. A rising edge on a direction clock is found by comparing the current sample with the sample from the previous cycle. Each output is a data word plus a per-bit drive enable. The A-to-B enable is active high and the B-to-A enable is active low.

Each input port has a per-bit "driven" qualifier. Any bit that is not driven takes its value from a bus keeper, which remembers the last level driven on that bit. A flag reports when both directions are enabled at once.

Top module: `univ_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage registers and both bus keepers to zero. Both data outputs read 0 after reset, and a fully undriven input loaded in transparent mode also gives 0.
- R2: While a direction's level control is high, its data output, one system clock later, equals that cycle's effective input.
- R3: When the level control goes low, the output keeps the value loaded in the last cycle the control was high, even if the input changes.
- R4: While the level control is low, a direction clock sampled high after being sampled low loads the effective input of that cycle. The new value appears on the output one system clock later.
- R5: While the level control is low, a direction clock held steady high, held steady low, or falling leaves the output unchanged.
- R6: `b_oe_o` is all ones while `ab_oe` is 1 and all zeros while it is 0, in the same cycle (active high).
- R7: `a_oe_o` is all ones while `ba_oe_n` is 0 and all zeros while it is 1, in the same cycle (active low).
- R8: Each input bit whose drive qualifier is 1 is taken from the pin, and the keeper remembers it. Each bit whose qualifier is 0 uses the level last driven on that bit. Driven and undriven bits may be mixed in one word.
- R9: `contend_o` is 1 exactly when `ab_oe` is 1 and `ba_oe_n` is 0.
- R10: The two directions are independent. Activity on one direction's controls and data leaves the other direction's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B level control (1 = transparent) |
| ab_cp | input | 1 | A-to-B direction clock |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A level control (1 = transparent) |
| ba_cp | input | 1 | B-to-A direction clock |
| a_pin_i | input | W | A port input data |
| a_drv_i | input | W | Per-bit "A bit is driven" qualifier |
| b_pin_i | input | W | B port input data |
| b_drv_i | input | W | Per-bit "B bit is driven" qualifier |
| b_out_o | output | W | Data presented to the B port |
| b_oe_o | output | W | Per-bit drive enable for the B port |
| a_out_o | output | W | Data presented to the A port |
| a_oe_o | output | W | Per-bit drive enable for the A port |
| contend_o | output | 1 | Both directions enabled at once |

## Verification
The hardest case to reach from the ports is a bit-wise mix inside the keeper. A word has to be stored, then only part of it overwritten by driven bits, then read back with nothing driven. That readback shows whether the undriven bits kept their old levels and the driven bits took their new ones. The vector table builds this case in order: it first clocks in a known word, then drives a word with no bits driven, then drives one with only the low byte driven, then one with no bits driven again. The bench also places a steady-high clock, a falling clock and a falling level control between clocked loads, so that a wrong load would show as a change in the held word.

// File: rtl/univ_xcvr_pkg.sv
package univ_xcvr_pkg;
   // Per-cycle action chosen for one direction's storage register
   typedef enum logic [1:0] {
      ACT_FOLLOW = 2'd0,   // level control high: reload every cycle
      ACT_CAPTURE = 2'd1,  // level control low, clock rose: load once
      ACT_KEEP = 2'd2      // otherwise: hold
   } lane_act_e;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
   parameter int unsigned W = 18,
   parameter bit KEEP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] drv,
   output logic [W-1:0] eff
);
   generate
      if (W < 1) begin : g_bad_width
         $error("xcvr_keeper: W must be at least 1");
      end

      if (KEEP_EN) begin : g_keep
         logic [W-1:0] kept;

         // Driven bits come from the pin; undriven bits reuse the held level
         assign eff = (drv & pin) | (~drv & kept);

         always_ff @(posedge clk) begin
            if (rst) kept <= '0;
            else     kept <= eff;
         end

         // R8: a fully driven word is remembered
         a_r8_keep_driven: assert property (@(posedge clk) disable iff (rst)
            (drv == {W{1'b1}}) |=> (kept == $past(pin)));
         // R8: with nothing driven the held word does not move
         a_r8_keep_hold: assert property (@(posedge clk) disable iff (rst)
            (drv == '0) |=> $stable(kept));
      end else begin : g_pass
         logic unused_drv;
         assign unused_drv = ^{drv, clk, rst};
         assign eff = pin;
      end
   endgenerate
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import univ_xcvr_pkg::*;
#(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         le,
   input  logic         cp,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic      cp_q;
   lane_act_e act;

   generate
      if (W < 1) begin : g_bad_width
         $error("xcvr_lane: W must be at least 1");
      end
   endgenerate

   always_comb begin
      if (le)                act = ACT_FOLLOW;
      else if (cp && !cp_q)  act = ACT_CAPTURE;
      else                   act = ACT_KEEP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q    <= '0;
         cp_q <= 1'b0;
      end else begin
         cp_q <= cp;
         if (act != ACT_KEEP) q <= din;
      end
   end

   // R2: transparent mode reloads from the input
   a_r2_follow: assert property (@(posedge clk) disable iff (rst)
      le |=> (q == $past(din)));
   // R4: sampled clock rise with level low captures the input
   a_r4_capture: assert property (@(posedge clk) disable iff (rst)
      (!le && cp && !cp_q) |=> (q == $past(din)));
   // R3 / R5: level low without a clock rise holds storage
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!le && !(cp && !cp_q)) |=> $stable(q));
endmodule

// File: rtl/univ_xcvr.sv
module univ_xcvr #(
   parameter int unsigned W = 18,
   parameter bit KEEP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ab_oe,
   input  logic         ab_le,
   input  logic         ab_cp,
   input  logic         ba_oe_n,
   input  logic         ba_le,
   input  logic         ba_cp,
   input  logic [W-1:0] a_pin_i,
   input  logic [W-1:0] a_drv_i,
   input  logic [W-1:0] b_pin_i,
   input  logic [W-1:0] b_drv_i,
   output logic [W-1:0] b_out_o,
   output logic [W-1:0] b_oe_o,
   output logic [W-1:0] a_out_o,
   output logic [W-1:0] a_oe_o,
   output logic         contend_o
);
   logic [W-1:0] a_eff, b_eff;

   generate
      if (W < 1) begin : g_bad_width
         $error("univ_xcvr: W must be at least 1");
      end
   endgenerate

   xcvr_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_a (
      .clk(clk), .rst(rst), .pin(a_pin_i), .drv(a_drv_i), .eff(a_eff));
   xcvr_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_b (
      .clk(clk), .rst(rst), .pin(b_pin_i), .drv(b_drv_i), .eff(b_eff));

   xcvr_lane #(.W(W)) u_lane_ab (
      .clk(clk), .rst(rst), .le(ab_le), .cp(ab_cp), .din(a_eff), .q(b_out_o));
   xcvr_lane #(.W(W)) u_lane_ba (
      .clk(clk), .rst(rst), .le(ba_le), .cp(ba_cp), .din(b_eff), .q(a_out_o));

   assign b_oe_o    = {W{ab_oe}};
   assign a_oe_o    = {W{~ba_oe_n}};
   assign contend_o = ab_oe & ~ba_oe_n;

   // R9: a raised flag means both ports are being driven
   a_r9_contention: assert property (@(posedge clk) disable iff (rst)
      contend_o |-> ((b_oe_o != '0) && (a_oe_o != '0)));
endmodule

// File: tb/univ_xcvr_test.sv
module univ_xcvr_test;
   localparam int W = 18;
   localparam int NV = 10;
   // {le, cp, data, drv, expected b_out}
   localparam logic [55:0] VEC [NV] = '{
      {1'b1, 1'b0, 18'h2A5A5, 18'h3FFFF, 18'h2A5A5},  // R2
      {1'b1, 1'b0, 18'h15A5A, 18'h3FFFF, 18'h15A5A},  // R2
      {1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 18'h15A5A},  // R3
      {1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF},  // R4
      {1'b0, 1'b1, 18'h00000, 18'h3FFFF, 18'h3FFFF},  // R5 steady high
      {1'b0, 1'b0, 18'h00000, 18'h3FFFF, 18'h3FFFF},  // R5 falling
      {1'b0, 1'b1, 18'h12345, 18'h3FFFF, 18'h12345},  // R4
      {1'b1, 1'b0, 18'h3FFFF, 18'h00000, 18'h12345},  // R8 nothing driven
      {1'b1, 1'b0, 18'h00000, 18'h000FF, 18'h12300},  // R8 mixed
      {1'b1, 1'b0, 18'h3FFFF, 18'h00000, 18'h12300}   // R8 held mix
   };

   logic clk = 1'b0, rst = 1'b1;
   logic ab_oe = 1'b0, ab_le = 1'b0, ab_cp = 1'b0;
   logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0;
   logic [W-1:0] a_pin_i = '0, a_drv_i = '0, b_pin_i = '0, b_drv_i = '0;
   logic [W-1:0] b_out_o, b_oe_o, a_out_o, a_oe_o;
   logic contend_o;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   univ_xcvr #(.W(W)) uut (.*);

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 b_out after reset", b_out_o, '0);
      chk("R1 a_out after reset", a_out_o, '0);

      // Enables and contention are combinational
      ab_oe = 0; ba_oe_n = 1; #1;
      chk("R6 b_oe off", b_oe_o, '0);
      chk("R7 a_oe off", a_oe_o, '0);
      chk("R9 no contention", {17'd0, contend_o}, 18'd0);
      ab_oe = 1; #1;
      chk("R6 b_oe on", b_oe_o, '1);
      chk("R9 only ab", {17'd0, contend_o}, 18'd0);
      ba_oe_n = 0; #1;
      chk("R7 a_oe on", a_oe_o, '1);
      chk("R9 both enabled", {17'd0, contend_o}, 18'd1);
      ab_oe = 0; #1;
      chk("R9 only ba", {17'd0, contend_o}, 18'd0);
      chk("R6 b_oe off again", b_oe_o, '0);
      ba_oe_n = 1; #1;

      // A-to-B vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ab_le = VEC[i][55];
         ab_cp = VEC[i][54];
         a_pin_i = VEC[i][53:36];
         a_drv_i = VEC[i][35:18];
         @(negedge clk);
         chk($sformatf("R2/R3/R4/R5/R8 vector %0d", i), b_out_o, VEC[i][17:0]);
      end
      chk("R10 a_out untouched by A-to-B activity", a_out_o, '0);

      // B-to-A path in transparent mode
      @(negedge clk);
      ab_le = 0; ab_cp = 0;
      ba_le = 1; b_pin_i = 18'h0AAAA; b_drv_i = '1;
      @(negedge clk);
      chk("R2 B-to-A transparent", a_out_o, 18'h0AAAA);
      chk("R10 b_out untouched by B-to-A activity", b_out_o, 18'h12300);
      ba_le = 0; b_pin_i = 18'h3C3C3;
      @(negedge clk);
      chk("R3 B-to-A level fall holds", a_out_o, 18'h0AAAA);
      ba_cp = 1;
      @(negedge clk);
      chk("R4 B-to-A clock capture", a_out_o, 18'h3C3C3);

      // Reset clears keepers too
      rst = 1;
      @(negedge clk);
      rst = 0; ba_cp = 0;
      chk("R1 b_out cleared", b_out_o, '0);
      chk("R1 a_out cleared", a_out_o, '0);
      ab_le = 1; a_drv_i = '0; a_pin_i = '1;
      @(negedge clk);
      chk("R1 keeper cleared", b_out_o, '0);

      finish_run();
   end
endmodule